// File: doc/BRIEF.md
# CAN Global Access-Error Interrupt Detector

This block sits beside the register bus of a multi-module CAN controller. It watches every access, sorts the address into one of four classes by range comparison (global control registers, temporary buffer, per-module registers, unused space), and checks the access against rules that depend on a global operating-mode bit. When an access breaks a rule, the block raises a sticky cause flag. The flags feed two level-sensitive interrupt request lines, and each line has its own software enable.

The block holds three small global registers: the operating-mode bit, the two interrupt enables, and the cause flags. Software turns the mode on by writing a 1 to the mode register. Turning it off succeeds only when forced shutdown is permitted or every CAN module reports that it is in initialization state. A refused attempt leaves the mode on and raises a cause flag. The real register file and the message buffers are outside this block.

Top module: `can_gerr_irq`

## Requirements
- R1: Any access, read or write, to an address outside the three defined ranges sets cause bit 0 one cycle later. With the default parameters the defined ranges are global 0x00–0x02, temporary buffer 0x10–0x1F and module registers 0x40–0x7F.
- R2: A write of 0 in data bit 0 to the mode register (global offset 0) while the mode is 1 is refused when the shutdown permit is 0 and at least one bit of the module init flags is 0. In that case the mode stays 1 and cause bit 1 sets. Otherwise the mode clears and no flag is raised.
- R3: A write to the temporary buffer while the mode is 1 sets cause bit 2. Reads of that range, and writes to it while the mode is 0, raise nothing.
- R4: Any access to the module-register range while the mode is 0 sets cause bit 3. The same access while the mode is 1 raises nothing.
- R5: A write to the enable register (global offset 1) updates both enables independently. Data bit 0 sets enable 1 and bit 1 clears it; bit 2 sets enable 2 and bit 3 clears it. A clear bit takes precedence over a set bit, and an enable whose set and clear bits are both 0 keeps its value.
- R6: Cause flags are sticky. A write to the cause register (global offset 2) clears exactly the flags whose data bits are 1 and leaves the others unchanged.
- R7: irq_o[0] equals enable 1 AND (cause bit 0 OR cause bit 1). irq_o[1] equals enable 2 AND (cause bit 2 OR cause bit 3). Both are levels and follow the registered state without further delay.
- R8: After reset the mode is 0, both enables are 0, all cause flags are 0 and both interrupt lines are low.
- R9: A write of 1 in data bit 0 to the mode register sets the mode whatever the shutdown permit and module init flags are.
- R10: Accesses to the global registers never raise any cause flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid_i | input | 1 | Bus access strobe, one access per cycle |
| acc_write_i | input | 1 | 1 = write, 0 = read |
| acc_addr_i | input | ADDR_W | Access word address |
| acc_wdata_i | input | 4 | Write data, used by the global registers |
| sd_force_i | input | 1 | Forced-shutdown permit |
| mod_init_i | input | N_MOD | Per-module initialization-state flags |
| op_mode_o | output | 1 | Global operating-mode bit |
| cause_o | output | 4 | Sticky cause flags |
| irq_o | output | 2 | Interrupt request lines 1 (bit 0) and 2 (bit 1) |

## Verification
Every address of the 8-bit space is accessed both as a read and as a write, once with the mode off and once with it on. This separates the range boundaries from one another and shows which violations depend on direction and which on mode. The refused-clear rule is run over all combinations of shutdown permit and module init flags, so the single permitting case of each input is distinguished from the blocking ones. All enable write patterns are applied from every starting enable state. This exposes set/clear precedence and hold. All cause patterns are combined with all enable states to verify the per-line gating and the bit-selective clearing.

// File: rtl/cgerr_pkg.sv
package cgerr_pkg;

    localparam int CTRL_W  = 4;
    localparam int N_CAUSE = 4;
    localparam int N_LINE  = 2;
    localparam int N_GREG  = 3;

    localparam int GOFF_MODE  = 0;
    localparam int GOFF_IEN   = 1;
    localparam int GOFF_CAUSE = 2;

    localparam int C_UNDEF   = 0;
    localparam int C_MODECLR = 1;
    localparam int C_TMPWR   = 2;
    localparam int C_MODACC  = 3;

    typedef enum logic [1:0] {
        RGN_GLB   = 2'd0,
        RGN_TMP   = 2'd1,
        RGN_MOD   = 2'd2,
        RGN_UNDEF = 2'd3
    } region_e;

    typedef struct packed {
        logic                mode;
        logic [N_LINE-1:0]   en;
        logic [N_CAUSE-1:0]  cause;
    } gstate_t;

    // Which cause flags feed which interrupt line
    function automatic logic [N_CAUSE-1:0] line_mask(input int line);
        logic [N_CAUSE-1:0] m;
        m = '0;
        if (line == 0) begin
            m[C_UNDEF]   = 1'b1;
            m[C_MODECLR] = 1'b1;
        end else begin
            m[C_TMPWR]   = 1'b1;
            m[C_MODACC]  = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/cgerr_decode.sv
module cgerr_decode
    import cgerr_pkg::*;
#(
    parameter int          ADDR_W   = 8,
    parameter int unsigned GLB_BASE = 32'h00,
    parameter int unsigned TMP_BASE = 32'h10,
    parameter int unsigned TMP_SIZE = 16,
    parameter int unsigned MOD_BASE = 32'h40,
    parameter int unsigned MOD_SPAN = 16,
    parameter int          N_MOD    = 4
) (
    input  logic [ADDR_W-1:0] addr_i,
    output region_e           region_o,
    output logic [N_GREG-1:0] gsel_o
);

    localparam int unsigned TMP_END = TMP_BASE + TMP_SIZE;

    logic [31:0]      a32;
    logic [N_MOD-1:0] mod_hit;
    logic             tmp_hit;

    assign a32     = 32'(addr_i);
    assign tmp_hit = (a32 >= TMP_BASE) && (a32 < TMP_END);

    for (genvar g = 0; g < N_GREG; g++) begin : g_glb
        assign gsel_o[g] = (a32 == GLB_BASE + 32'(g));
    end

    for (genvar m = 0; m < N_MOD; m++) begin : g_mod
        localparam int unsigned LO = MOD_BASE + 32'(m) * MOD_SPAN;
        localparam int unsigned HI = LO + MOD_SPAN;
        assign mod_hit[m] = (a32 >= LO) && (a32 < HI);
    end

    always_comb begin
        if (|gsel_o)       region_o = RGN_GLB;
        else if (tmp_hit)  region_o = RGN_TMP;
        else if (|mod_hit) region_o = RGN_MOD;
        else               region_o = RGN_UNDEF;
    end

endmodule

// File: rtl/cgerr_rules.sv
module cgerr_rules
    import cgerr_pkg::*;
#(
    parameter int N_MOD = 4
) (
    input  logic               valid_i,
    input  logic               write_i,
    input  logic               req_on_i,
    input  region_e            region_i,
    input  logic [N_GREG-1:0]  gsel_i,
    input  logic               mode_q_i,
    input  logic               sd_force_i,
    input  logic [N_MOD-1:0]   mod_init_i,
    output logic [N_CAUSE-1:0] viol_o,
    output logic               mode_d_o,
    output logic               ien_wr_o,
    output logic               cause_wr_o
);

    logic glb_wr;
    logic mode_wr;
    logic clr_try;
    logic blocked;

    assign glb_wr     = valid_i && write_i && (region_i == RGN_GLB);
    assign mode_wr    = glb_wr && gsel_i[GOFF_MODE];
    assign ien_wr_o   = glb_wr && gsel_i[GOFF_IEN];
    assign cause_wr_o = glb_wr && gsel_i[GOFF_CAUSE];

    assign blocked = !sd_force_i && !(&mod_init_i);
    assign clr_try = mode_wr && !req_on_i && mode_q_i;

    always_comb begin
        viol_o            = '0;
        viol_o[C_UNDEF]   = valid_i && (region_i == RGN_UNDEF);
        viol_o[C_MODECLR] = clr_try && blocked;
        viol_o[C_TMPWR]   = valid_i && write_i && (region_i == RGN_TMP) && mode_q_i;
        viol_o[C_MODACC]  = valid_i && (region_i == RGN_MOD) && !mode_q_i;
    end

    always_comb begin
        mode_d_o = mode_q_i;
        if (mode_wr) begin
            if (req_on_i)      mode_d_o = 1'b1;
            else if (!blocked) mode_d_o = 1'b0;
        end
    end

endmodule

// File: rtl/cgerr_irq.sv
module cgerr_irq
    import cgerr_pkg::*;
(
    input  logic [N_CAUSE-1:0] cause_i,
    input  logic [N_LINE-1:0]  en_i,
    output logic [N_LINE-1:0]  irq_o
);

    for (genvar l = 0; l < N_LINE; l++) begin : g_line
        localparam logic [N_CAUSE-1:0] MASK = line_mask(l);
        assign irq_o[l] = en_i[l] && |(cause_i & MASK);
    end

endmodule

// File: rtl/can_gerr_irq.sv
module can_gerr_irq
    import cgerr_pkg::*;
#(
    parameter int          ADDR_W   = 8,
    parameter int unsigned GLB_BASE = 32'h00,
    parameter int unsigned TMP_BASE = 32'h10,
    parameter int unsigned TMP_SIZE = 16,
    parameter int unsigned MOD_BASE = 32'h40,
    parameter int unsigned MOD_SPAN = 16,
    parameter int          N_MOD    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid_i,
    input  logic              acc_write_i,
    input  logic [ADDR_W-1:0] acc_addr_i,
    input  logic [CTRL_W-1:0] acc_wdata_i,
    input  logic              sd_force_i,
    input  logic [N_MOD-1:0]  mod_init_i,
    output logic              op_mode_o,
    output logic [N_CAUSE-1:0] cause_o,
    output logic [N_LINE-1:0] irq_o
);

    region_e            rgn;
    logic [N_GREG-1:0]  gsel;
    logic [N_CAUSE-1:0] viol;
    logic               mode_d;
    logic               ien_wr;
    logic               cause_wr;
    gstate_t            st_d;
    gstate_t            st_q;

    cgerr_decode #(
        .ADDR_W  (ADDR_W),
        .GLB_BASE(GLB_BASE),
        .TMP_BASE(TMP_BASE),
        .TMP_SIZE(TMP_SIZE),
        .MOD_BASE(MOD_BASE),
        .MOD_SPAN(MOD_SPAN),
        .N_MOD   (N_MOD)
    ) u_dec (
        .addr_i  (acc_addr_i),
        .region_o(rgn),
        .gsel_o  (gsel)
    );

    cgerr_rules #(
        .N_MOD(N_MOD)
    ) u_rules (
        .valid_i   (acc_valid_i),
        .write_i   (acc_write_i),
        .req_on_i  (acc_wdata_i[0]),
        .region_i  (rgn),
        .gsel_i    (gsel),
        .mode_q_i  (st_q.mode),
        .sd_force_i(sd_force_i),
        .mod_init_i(mod_init_i),
        .viol_o    (viol),
        .mode_d_o  (mode_d),
        .ien_wr_o  (ien_wr),
        .cause_wr_o(cause_wr)
    );

    always_comb begin
        st_d      = st_q;
        st_d.mode = mode_d;
        if (ien_wr) begin
            for (int l = 0; l < N_LINE; l++) begin
                if (acc_wdata_i[2*l+1])    st_d.en[l] = 1'b0;
                else if (acc_wdata_i[2*l]) st_d.en[l] = 1'b1;
            end
        end
        if (cause_wr) st_d.cause = st_q.cause & ~acc_wdata_i;
        st_d.cause = st_d.cause | viol;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    cgerr_irq u_irq (
        .cause_i(st_q.cause),
        .en_i   (st_q.en),
        .irq_o  (irq_o)
    );

    assign op_mode_o = st_q.mode;
    assign cause_o   = st_q.cause;

endmodule

// File: rtl/cgerr_chk.sv
module cgerr_chk
    import cgerr_pkg::*;
#(
    parameter int N_MOD = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               acc_valid_i,
    input logic               acc_write_i,
    input logic [CTRL_W-1:0]  acc_wdata_i,
    input logic               sd_force_i,
    input logic [N_MOD-1:0]   mod_init_i,
    input region_e            rgn,
    input logic [N_GREG-1:0]  gsel,
    input logic               op_mode_o,
    input logic [N_CAUSE-1:0] cause_o,
    input logic [N_LINE-1:0]  irq_o
);

    logic [N_CAUSE-1:0] w1c;
    assign w1c = (acc_valid_i && acc_write_i && rgn == RGN_GLB && gsel[GOFF_CAUSE])
                 ? acc_wdata_i : '0;

    p_undef_flag_r1: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid_i && rgn == RGN_UNDEF |=> cause_o[C_UNDEF]);

    p_clr_refused_r2: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid_i && acc_write_i && rgn == RGN_GLB && gsel[GOFF_MODE] && !acc_wdata_i[0]
        && op_mode_o && !sd_force_i && !(&mod_init_i)
        |=> op_mode_o && cause_o[C_MODECLR]);

    p_tmp_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid_i && acc_write_i && rgn == RGN_TMP && op_mode_o |=> cause_o[C_TMPWR]);

    p_mod_access_r4: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid_i && rgn == RGN_MOD && !op_mode_o |=> cause_o[C_MODACC]);

    p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        |cause_o |=> (($past(cause_o & ~w1c) & ~cause_o) == '0));

    p_line1_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o[0] |-> (cause_o[C_UNDEF] || cause_o[C_MODECLR]));

    p_line2_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o[1] |-> (cause_o[C_TMPWR] || cause_o[C_MODACC]));

    p_mode_on_r9: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid_i && acc_write_i && rgn == RGN_GLB && gsel[GOFF_MODE] && acc_wdata_i[0]
        |=> op_mode_o);

endmodule

bind can_gerr_irq cgerr_chk #(.N_MOD(N_MOD)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_valid_i(acc_valid_i),
    .acc_write_i(acc_write_i),
    .acc_wdata_i(acc_wdata_i),
    .sd_force_i (sd_force_i),
    .mod_init_i (mod_init_i),
    .rgn        (rgn),
    .gsel       (gsel),
    .op_mode_o  (op_mode_o),
    .cause_o    (cause_o),
    .irq_o      (irq_o)
);

// File: tb/tb_can_gerr_irq.sv
module tb_can_gerr_irq;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       acc_valid_i = 1'b0;
    logic       acc_write_i = 1'b0;
    logic [7:0] acc_addr_i = '0;
    logic [3:0] acc_wdata_i = '0;
    logic       sd_force_i = 1'b1;
    logic [3:0] mod_init_i = 4'hF;
    logic       op_mode_o;
    logic [3:0] cause_o;
    logic [1:0] irq_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    can_gerr_irq dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_valid_i(acc_valid_i),
        .acc_write_i(acc_write_i),
        .acc_addr_i (acc_addr_i),
        .acc_wdata_i(acc_wdata_i),
        .sd_force_i (sd_force_i),
        .mod_init_i (mod_init_i),
        .op_mode_o  (op_mode_o),
        .cause_o    (cause_o),
        .irq_o      (irq_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bus(input logic wr, input int addr, input logic [3:0] d);
        @(negedge clk);
        acc_valid_i = 1'b1;
        acc_write_i = wr;
        acc_addr_i  = addr[7:0];
        acc_wdata_i = d;
        @(negedge clk);
        acc_valid_i = 1'b0;
        acc_write_i = 1'b0;
        acc_wdata_i = '0;
    endtask

    task automatic set_mode(input logic m);
        logic sv;
        sv = sd_force_i;
        sd_force_i = 1'b1;
        bus(1'b1, 0, {3'b000, m});
        sd_force_i = sv;
    endtask

    task automatic clr_all();
        bus(1'b1, 2, 4'hF);
    endtask

    function automatic bit in_glb(input int a); return a < 3; endfunction
    function automatic bit in_tmp(input int a); return a >= 16 && a < 32; endfunction
    function automatic bit in_mod(input int a); return a >= 64 && a < 128; endfunction

    // Build an exact cause pattern c using real violations
    task automatic make_causes(input logic [3:0] c);
        clr_all();
        set_mode(1'b1);
        if (c[1]) begin
            sd_force_i = 1'b0;
            mod_init_i = 4'h0;
            bus(1'b1, 0, 4'h0);
            sd_force_i = 1'b1;
            mod_init_i = 4'hF;
        end
        if (c[2]) bus(1'b1, 8'h10, 4'h0);
        set_mode(1'b0);
        if (c[3]) bus(1'b0, 8'h40, 4'h0);
        if (c[0]) bus(1'b0, 8'h80, 4'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R8: reset state
        chk("R8 mode", int'(op_mode_o), 0);
        chk("R8 cause", int'(cause_o), 0);
        chk("R8 irq", int'(irq_o), 0);
        rst_n = 1'b1;

        // R1 R3 R4 R10: full address sweep, read and write, both modes
        for (int m = 0; m < 2; m++) begin
            for (int w = 0; w < 2; w++) begin
                for (int a = 0; a < 256; a++) begin
                    logic [3:0] exp_c;
                    string tag;
                    set_mode(m[0]);
                    clr_all();
                    bus(w[0], a, 4'h0);
                    exp_c = '0;
                    exp_c[0] = !in_glb(a) && !in_tmp(a) && !in_mod(a);
                    exp_c[2] = in_tmp(a) && w == 1 && m == 1;
                    exp_c[3] = in_mod(a) && m == 0;
                    if (in_glb(a))      tag = "R10";
                    else if (in_tmp(a)) tag = "R3";
                    else if (in_mod(a)) tag = "R4";
                    else                tag = "R1";
                    chk($sformatf("%s cause a=%0h w=%0d m=%0d", tag, a, w, m),
                        int'(cause_o), int'(exp_c));
                    chk($sformatf("%s mode a=%0h w=%0d m=%0d", tag, a, w, m),
                        int'(op_mode_o), (a == 0 && w == 1) ? 0 : m);
                end
            end
        end

        // R2 R9: clear attempts over every permit / init combination
        for (int sd = 0; sd < 2; sd++) begin
            for (int ini = 0; ini < 16; ini++) begin
                bit blk;
                sd_force_i = 1'b0;
                mod_init_i = ini[3:0];
                bus(1'b1, 0, 4'h1);
                chk($sformatf("R9 set sd=%0d init=%0h", sd, ini), int'(op_mode_o), 1);
                sd_force_i = 1'b1;
                clr_all();
                sd_force_i = sd[0];
                bus(1'b1, 0, 4'h0);
                blk = (sd == 0) && (ini != 15);
                chk($sformatf("R2 mode sd=%0d init=%0h", sd, ini), int'(op_mode_o), int'(blk));
                chk($sformatf("R2 cause sd=%0d init=%0h", sd, ini), int'(cause_o),
                    blk ? 2 : 0);
                sd_force_i = 1'b1;
                mod_init_i = 4'hF;
                set_mode(1'b0);
            end
        end

        // R5: every enable write pattern from every start state
        make_causes(4'b1001);
        for (int s = 0; s < 4; s++) begin
            for (int p = 0; p < 16; p++) begin
                logic e1, e2;
                bus(1'b1, 1, {~s[1], s[1], ~s[0], s[0]});
                bus(1'b1, 1, p[3:0]);
                e1 = p[1] ? 1'b0 : (p[0] ? 1'b1 : s[0]);
                e2 = p[3] ? 1'b0 : (p[2] ? 1'b1 : s[1]);
                chk($sformatf("R5 start=%0d pat=%0h", s, p), int'(irq_o), int'({e2, e1}));
            end
        end

        // R6 R7: cause patterns against enable states
        for (int c = 0; c < 16; c++) begin
            for (int e = 0; e < 4; e++) begin
                logic [1:0] exp_i;
                make_causes(c[3:0]);
                bus(1'b1, 1, {~e[1], e[1], ~e[0], e[0]});
                exp_i[0] = e[0] && (c[0] || c[1]);
                exp_i[1] = e[1] && (c[2] || c[3]);
                chk($sformatf("R6 hold c=%0h e=%0d", c, e), int'(cause_o), c);
                chk($sformatf("R7 irq c=%0h e=%0d", c, e), int'(irq_o), int'(exp_i));
            end
        end

        // R6: selective write-one clear
        for (int k = 0; k < 16; k++) begin
            make_causes(4'hF);
            bus(1'b1, 2, k[3:0]);
            chk($sformatf("R6 w1c mask=%0h", k), int'(cause_o), int'(4'hF & ~k[3:0]));
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule